// File: doc/BRIEF.md
# Interrupt Source Capture Unit

This block watches a bank of asynchronous system interrupt lines and turns each line into a pending status bit. Every source has two configuration bits of its own. The trigger kind bit picks edge or level detection, and the sense bit picks which edge or which level counts as active. Each line passes through a synchroniser before anything is detected on it.

Software reaches the block over a simple single-cycle write port and a combinational read port. Sources are packed 32 to a word. Word-wide registers set or clear every bit written as 1. Index registers take a source number as data and touch only that source's bit, so no read-modify-write is needed. Acknowledging an interrupt means writing its number to the status index-clear register.

The output `pending` carries the status bits of the enabled sources. Channel mapping and priority logic further downstream read it.

Top module: `irq_capture`

## Requirements
- R1: Reset clears every enable, status, trigger kind and sense bit to 0, so `pending` reads 0 while reset is held.
- R2: A source with kind 1 (edge) and sense 1 sets its status bit on the third rising clock edge after its input rises. A falling input does not set it.
- R3: A source with kind 1 and sense 0 sets its status on the third clock edge after its input falls. A rising input does not set it.
- R4: An edge-captured status bit stays set after the input returns to its inactive value, until it is cleared by a write.
- R5: A source with kind 0 (level) has a status bit equal to its synchronised active level: the input high when sense is 1, low when sense is 0. The status follows the input with the same three-edge latency. A clear written while the level is active leaves the bit at 1.
- R6: Writing source number n to function 10 (enable index-set) sets only enable bit n. Writing it to function 11 (enable index-clear) clears only enable bit n.
- R7: Writing n to function 8 (status index-set) sets only status bit n. Writing n to function 9 (status index-clear, the acknowledge) clears only status bit n.
- R8: The word-wide functions 1 and 2 (status set and clear) and 4 and 5 (enable set and clear) act on each bit written as 1 and leave the bits written as 0 alone. Writing all ones to a clear function clears the whole word.
- R9: The address is {function[3:0], word}. Source n lives in word n/32 at bit n%32. Functions 0, 3, 6 and 7 read back status, enable, kind and sense, and bits past the last source read as 0.
- R10: An index write whose data is not below NUM_SRC changes nothing.
- R11: `pending` equals status AND enable, bit for bit.
- R12: If an active edge and a status clear on the same edge-mode source land in the same clock cycle, the status bit ends up set.
- R13: Writes to function 6 (kind) and function 7 (sense) load the addressed word from the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| irq_in | input | NUM_SRC | Raw interrupt lines, asynchronous |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write address {function, word} |
| wr_data | input | 32 | Write data: a bit mask or a source number |
| rd_addr | input | ADDR_W | Read address {function, word} |
| rd_data | output | 32 | Combinational read data |
| pending | output | NUM_SRC | Enabled pending sources |

## Verification
Two things can act on one status bit in the same cycle: a detected active edge and a software clear. The bench provokes this by raising a source's input and then timing an index-clear write so that it is registered on the same clock edge as the edge detection. After that edge the status bit must read 1. The per-source sweep adds a second overlap for level mode, an acknowledge written while the level is still active, where the bit must stay at 1.

// File: rtl/isc_pkg.sv
package isc_pkg;
    localparam int WORD_BITS = 32;

    // write/read function codes: upper four address bits
    localparam logic [3:0] F_STAT      = 4'd0;
    localparam logic [3:0] F_STAT_SET  = 4'd1;
    localparam logic [3:0] F_STAT_CLR  = 4'd2;
    localparam logic [3:0] F_ENA       = 4'd3;
    localparam logic [3:0] F_ENA_SET   = 4'd4;
    localparam logic [3:0] F_ENA_CLR   = 4'd5;
    localparam logic [3:0] F_KIND      = 4'd6;
    localparam logic [3:0] F_SENSE     = 4'd7;
    localparam logic [3:0] F_STAT_ISET = 4'd8;
    localparam logic [3:0] F_STAT_ICLR = 4'd9;
    localparam logic [3:0] F_ENA_ISET  = 4'd10;
    localparam logic [3:0] F_ENA_ICLR  = 4'd11;
endpackage

// File: rtl/isc_sync.sv
module isc_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prv
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = din;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) sync_q <= '0;
        else     sync_q <= sync_d;
    end

    assign lvl = sync_q.s2;
    assign prv = sync_q.s3;
endmodule

// File: rtl/isc_wr_decode.sv
module isc_wr_decode
    import isc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 5,
    parameter int WORD_AW = 1
) (
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    output logic [NUM_SRC-1:0] ena_set,
    output logic [NUM_SRC-1:0] ena_clr,
    output logic [NUM_SRC-1:0] st_set,
    output logic [NUM_SRC-1:0] st_clr,
    output logic [NUM_SRC-1:0] kind_we,
    output logic [NUM_SRC-1:0] sense_we,
    output logic [NUM_SRC-1:0] wbits
);
    logic [3:0]         fn;
    logic [WORD_AW-1:0] wsel;

    assign fn   = wr_addr[ADDR_W-1 -: 4];
    assign wsel = wr_addr[WORD_AW-1:0];

    always_comb begin
        ena_set  = '0;
        ena_clr  = '0;
        st_set   = '0;
        st_clr   = '0;
        kind_we  = '0;
        sense_we = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            logic in_word;
            logic hot;
            logic b;
            in_word  = wr_en && (wsel == WORD_AW'(i / WORD_BITS));
            hot      = wr_en && (wr_data == 32'(i));
            b        = wr_data[i % WORD_BITS];
            wbits[i] = b;
            case (fn)
                F_STAT_SET:  st_set[i]   = in_word & b;
                F_STAT_CLR:  st_clr[i]   = in_word & b;
                F_ENA_SET:   ena_set[i]  = in_word & b;
                F_ENA_CLR:   ena_clr[i]  = in_word & b;
                F_KIND:      kind_we[i]  = in_word;
                F_SENSE:     sense_we[i] = in_word;
                F_STAT_ISET: st_set[i]   = hot;
                F_STAT_ICLR: st_clr[i]   = hot;
                F_ENA_ISET:  ena_set[i]  = hot;
                F_ENA_ICLR:  ena_clr[i]  = hot;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_capture.sv
module irq_capture
    import isc_pkg::*;
#(
    parameter int  NUM_SRC   = 64,
    localparam int NUM_WORDS = (NUM_SRC + WORD_BITS - 1) / WORD_BITS,
    localparam int WORD_AW   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int ADDR_W    = 4 + WORD_AW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [31:0]        rd_data,
    output logic [NUM_SRC-1:0] pending
);
    typedef struct packed {
        logic [NUM_SRC-1:0] ena;
        logic [NUM_SRC-1:0] stat;
        logic [NUM_SRC-1:0] kind;
        logic [NUM_SRC-1:0] sense;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NUM_SRC-1:0] lvl, prv;
    logic [NUM_SRC-1:0] ena_set, ena_clr, st_set, st_clr;
    logic [NUM_SRC-1:0] kind_we, sense_we, wbits;
    logic [NUM_SRC-1:0] active, hit;
    logic [NUM_SRC-1:0] ena_vec, stat_vec, kind_vec;

    isc_sync #(.W(NUM_SRC)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (irq_in),
        .lvl (lvl),
        .prv (prv)
    );

    isc_wr_decode #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W),
        .WORD_AW (WORD_AW)
    ) u_dec (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ena_set  (ena_set),
        .ena_clr  (ena_clr),
        .st_set   (st_set),
        .st_clr   (st_clr),
        .kind_we  (kind_we),
        .sense_we (sense_we),
        .wbits    (wbits)
    );

    always_comb begin
        regs_d = regs_q;
        // active level: input equals the sense bit
        active = ~(lvl ^ regs_q.sense);
        // qualified edge: rising when sense=1, falling when sense=0
        hit    = (regs_q.sense & lvl & ~prv) | (~regs_q.sense & ~lvl & prv);

        regs_d.ena   = (regs_q.ena & ~ena_clr) | ena_set;
        regs_d.kind  = (regs_q.kind & ~kind_we) | (wbits & kind_we);
        regs_d.sense = (regs_q.sense & ~sense_we) | (wbits & sense_we);
        // edge mode: sticky, new edge beats a clear; level mode: follow
        regs_d.stat  = (regs_q.kind & ((regs_q.stat & ~st_clr) | st_set | hit))
                     | (~regs_q.kind & active);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    always_comb begin
        logic [3:0]         rfn;
        logic [WORD_AW-1:0] rw;
        rfn     = rd_addr[ADDR_W-1 -: 4];
        rw      = rd_addr[WORD_AW-1:0];
        rd_data = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (rw == WORD_AW'(i / WORD_BITS)) begin
                case (rfn)
                    F_STAT:  rd_data[i % WORD_BITS] = regs_q.stat[i];
                    F_ENA:   rd_data[i % WORD_BITS] = regs_q.ena[i];
                    F_KIND:  rd_data[i % WORD_BITS] = regs_q.kind[i];
                    F_SENSE: rd_data[i % WORD_BITS] = regs_q.sense[i];
                    default: ;
                endcase
            end
        end
    end

    assign pending  = regs_q.stat & regs_q.ena;
    assign ena_vec  = regs_q.ena;
    assign stat_vec = regs_q.stat;
    assign kind_vec = regs_q.kind;
endmodule

// File: rtl/isc_checker.sv
module isc_checker
    import isc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 5,
    parameter int WORD_AW = 1
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [31:0]        wr_data,
    input logic [NUM_SRC-1:0] ena_vec,
    input logic [NUM_SRC-1:0] stat_vec,
    input logic [NUM_SRC-1:0] kind_vec,
    input logic [NUM_SRC-1:0] pending
);
    localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [3:0]         fn;
    logic [IW-1:0]      widx;
    logic               in_rng;
    logic [NUM_SRC-1:0] word_hit;
    logic               st_clr_wr;

    assign fn        = wr_addr[ADDR_W-1 -: 4];
    assign widx      = wr_data[IW-1:0];
    assign in_rng    = (wr_data < 32'(NUM_SRC));
    assign st_clr_wr = wr_en && (fn == F_STAT_CLR || fn == F_STAT_ICLR);

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++)
            word_hit[i] = (wr_addr[WORD_AW-1:0] == WORD_AW'(i / WORD_BITS));
    end

    AST_ENA_IDX_SET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fn == F_ENA_ISET && in_rng) |=> ena_vec[$past(widx)]); // R6

    AST_ENA_IDX_CLR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fn == F_ENA_ICLR && in_rng) |=> !ena_vec[$past(widx)]); // R6

    AST_IDX_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (fn == F_ENA_ISET || fn == F_ENA_ICLR) && !in_rng) |=> $stable(ena_vec)); // R10

    AST_WORD_CLR_ALL: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fn == F_ENA_CLR && wr_data == '1) |=> ((ena_vec & $past(word_hit)) == '0)); // R8

    AST_PEND_NEEDS_ENA: assert property (@(posedge clk) disable iff (rst)
        ((pending & ~ena_vec) == '0)); // R11

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_sticky
        AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
            (kind_vec[g] && stat_vec[g] && !st_clr_wr) |=> stat_vec[g]); // R4
    end
endmodule

bind irq_capture isc_checker #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .WORD_AW (WORD_AW)
) u_isc_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ena_vec  (ena_vec),
    .stat_vec (stat_vec),
    .kind_vec (kind_vec),
    .pending  (pending)
);

// File: tb/irq_capture_test.sv
`timescale 1ns/1ps
module irq_capture_test;
    localparam int N = 40;
    localparam logic [3:0] F_STAT = 0, F_STAT_SET = 1, F_STAT_CLR = 2, F_ENA = 3,
                           F_ENA_SET = 4, F_ENA_CLR = 5, F_KIND = 6, F_SENSE = 7,
                           F_STAT_ISET = 8, F_STAT_ICLR = 9, F_ENA_ISET = 10, F_ENA_ICLR = 11;

    logic         clk = 0;
    logic         rst = 1;
    logic [N-1:0] irq_in = '0;
    logic         wr_en = 0;
    logic [4:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [4:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic [N-1:0] pending;

    int total = 0;
    int bad = 0;

    logic [N-1:0] ena_m;
    logic [N-1:0] st_m;

    irq_capture #(.NUM_SRC(N)) uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pending(pending)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] f, input int w, input logic [31:0] d);
        wr_en   = 1;
        wr_addr = {f, w[0]};
        wr_data = d;
        @(negedge clk);
        wr_en   = 0;
    endtask

    task automatic rd(input logic [3:0] f, input int w, output logic [31:0] v);
        rd_addr = {f, w[0]};
        #1;
        v = rd_data;
    endtask

    task automatic chk_word(input string tag, input logic [3:0] f, input logic [N-1:0] m);
        logic [31:0] v0, v1;
        rd(f, 0, v0);
        rd(f, 1, v1);
        chk({tag, " w0"}, 64'(v0), 64'(m[31:0]));
        chk({tag, " w1"}, 64'(v1), 64'({24'd0, m[N-1:32]}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        ena_m = '0;
        st_m  = '0;
        repeat (3) @(negedge clk);
        // R1: all zero while reset held
        chk_word("R1 status", F_STAT, '0);
        chk_word("R1 enable", F_ENA, '0);
        chk_word("R1 kind", F_KIND, '0);
        chk_word("R1 sense", F_SENSE, '0);
        chk("R1 pending", 64'(pending), 64'd0);
        rst = 0;
        @(negedge clk);

        // baseline: rising edge everywhere, inputs low
        wr(F_KIND, 0, '1); wr(F_KIND, 1, '1);
        wr(F_SENSE, 0, '1); wr(F_SENSE, 1, '1);
        repeat (4) @(negedge clk);
        wr(F_STAT_CLR, 0, '1); wr(F_STAT_CLR, 1, '1);
        chk_word("R8 status cleared", F_STAT, '0);
        chk_word("R13 kind", F_KIND, '1);

        // R13: kind word load and readback, bits past the last source read 0 (R9)
        wr(F_KIND, 0, 32'h1234ABCD);
        wr(F_KIND, 1, 32'hFFFF_FFFF);
        rd(F_KIND, 0, v); chk("R13 kind w0", 64'(v), 64'h1234ABCD);
        rd(F_KIND, 1, v); chk("R9 kind w1 tail", 64'(v), 64'hFF);
        wr(F_KIND, 0, '1);
        repeat (3) @(negedge clk);
        wr(F_STAT_CLR, 0, '1);

        // R6 R10: index set sweep over 0..63
        for (int k = 0; k < 64; k++) begin
            wr(F_ENA_ISET, 0, 32'(k));
            if (k < N) ena_m[k] = 1'b1;
            chk_word(k < N ? "R6 idx set" : "R10 idx set oor", F_ENA, ena_m);
        end
        for (int k = 0; k < 64; k += 3) begin
            wr(F_ENA_ICLR, 1, 32'(k));
            if (k < N) ena_m[k] = 1'b0;
            chk_word(k < N ? "R6 idx clr" : "R10 idx clr oor", F_ENA, ena_m);
        end
        wr(F_ENA_ICLR, 0, 32'h8000_0001);
        chk_word("R10 idx huge", F_ENA, ena_m);

        // R8: word set/clear
        wr(F_ENA_CLR, 0, '1); wr(F_ENA_CLR, 1, '1);
        ena_m = '0;
        chk_word("R8 ena clear all", F_ENA, ena_m);
        wr(F_ENA_SET, 0, 32'hA5A5A5A5);
        wr(F_ENA_SET, 1, 32'h000000C3);
        wr(F_ENA_CLR, 0, 32'h0000FFFF);
        ena_m = {8'hC3, 32'hA5A50000};
        chk_word("R8 ena mask", F_ENA, ena_m);
        wr(F_STAT_SET, 0, 32'hF0F0F0F0);
        st_m = {8'h00, 32'hF0F0F0F0};
        chk_word("R8 stat set", F_STAT, st_m);
        chk("R11 pending", 64'(pending), 64'(st_m & ena_m));
        wr(F_STAT_CLR, 0, 32'h30303030);
        st_m = {8'h00, 32'hC0C0C0C0};
        chk_word("R8 stat clr", F_STAT, st_m);
        chk("R11 pending2", 64'(pending), 64'(st_m & ena_m));

        // R7: status index set, out of range ignored
        wr(F_STAT_ISET, 0, 32'd37);
        st_m[37] = 1'b1;
        chk_word("R7 stat idx set", F_STAT, st_m);
        wr(F_STAT_ISET, 0, 32'd45);
        chk_word("R10 stat idx oor", F_STAT, st_m);
        wr(F_STAT_ICLR, 0, 32'd38);
        chk_word("R7 stat idx clr other", F_STAT, st_m);
        wr(F_STAT_ICLR, 1, 32'd37);
        st_m[37] = 1'b0;
        chk_word("R7 stat idx clr", F_STAT, st_m);
        wr(F_STAT_CLR, 0, '1); wr(F_STAT_CLR, 1, '1);
        wr(F_ENA_CLR, 0, '1); wr(F_ENA_CLR, 1, '1);
        st_m = '0; ena_m = '0;
        chk("R11 pending zero", 64'(pending), 64'd0);

        // R12: edge on source 5 registered on the same edge as its acknowledge
        irq_in[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr(F_STAT_ICLR, 0, 32'd5);
        rd(F_STAT, 0, v);
        chk("R12 edge beats clear", 64'(v), 64'h20);
        irq_in[5] = 1'b0;
        repeat (3) @(negedge clk);
        wr(F_STAT_ICLR, 0, 32'd5);
        rd(F_STAT, 0, v);
        chk("R7 ack source 5", 64'(v), 64'h0);

        // per-source sweep over the four trigger modes
        for (int i = 0; i < N; i++) begin
            int w, b;
            logic [31:0] eb;
            w  = i / 32;
            b  = i % 32;
            eb = 32'(1) << b;
            for (int m = 0; m < 4; m++) begin
                logic t, p;
                string rq;
                t  = m[1];
                p  = m[0];
                rq = t ? (p ? "R2" : "R3") : "R5";
                wr(F_KIND, w, t ? 32'hFFFF_FFFF : ~eb);
                wr(F_SENSE, w, p ? 32'hFFFF_FFFF : ~eb);
                irq_in[i] = ~p;
                repeat (4) @(negedge clk);
                wr(F_STAT_CLR, w, '1);
                rd(F_STAT, w, v); chk({rq, " idle"}, 64'(v), 64'd0);
                wr(F_ENA_ISET, 0, 32'(i));
                irq_in[i] = p;
                repeat (2) @(negedge clk);
                rd(F_STAT, w, v); chk({rq, " latency early"}, 64'(v), 64'd0);
                @(negedge clk);
                rd(F_STAT, w, v); chk({rq, " captured"}, 64'(v), 64'(eb));
                chk("R11 pending one", 64'(pending), 64'(1) << i);
                if (!t) begin
                    wr(F_STAT_ICLR, 0, 32'(i));
                    rd(F_STAT, w, v); chk("R5 clear while active", 64'(v), 64'(eb));
                end
                irq_in[i] = ~p;
                repeat (3) @(negedge clk);
                rd(F_STAT, w, v);
                chk(t ? "R4 sticky" : "R5 follows low", 64'(v), t ? 64'(eb) : 64'd0);
                wr(F_STAT_ICLR, 0, 32'(i));
                rd(F_STAT, w, v); chk("R7 ack", 64'(v), 64'd0);
                wr(F_ENA_ICLR, 0, 32'(i));
                chk("R6 disabled", 64'(pending), 64'd0);
            end
            wr(F_KIND, w, '1);
            wr(F_SENSE, w, '1);
            irq_in[i] = 1'b0;
            repeat (4) @(negedge clk);
            wr(F_STAT_CLR, w, '1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule